// File: doc/BRIEF.md
# Strobe-Triggered DDR Word Serializer

The block turns a 22-bit parallel word into a 26-bit serial frame on one data line. A double-data-rate clock is forwarded beside that line. A word is sent only on demand: a rising edge on the strobe input, which has no fixed phase to the bit clock, passes through a two-flop synchronizer. At the detection edge the word on `din` is captured. With no strobe the line stays quiet, and both the data line and the forwarded clock sit low.

Each frame shows one bit per bit-clock cycle. The 22 payload bits come first, least significant bit first. A fixed four-bit boundary code follows them, so a receiver can find word edges from the stream alone. The forwarded clock is high while an odd-numbered bit is shown and low while an even-numbered bit is shown. Each clock edge therefore falls at the trailing edge of a data bit: a falling edge closes an odd bit and a rising edge closes an even bit. A frame spans 13 forwarded clock periods.

A strobe that arrives during a frame is kept in a one-word holding slot. Its frame follows the current one with no idle cycle. Dropping the enable input, or asserting reset, silences the outputs at once and throws away any held word.

Top module: `strobe_ddr_serializer`

## Requirements
- R1: While `rst` is high, or at the first clock edge at which `en` is sampled low, `sdata`, `sclk` and `busy` go to 0 and any held word is discarded, so that word is never sent.
- R2: A strobe rising edge is detected through two synchronizer flops. If `strobe` is first sampled high at clock edge P0 and the line is idle, `busy` stays 0 after P1, and after P2 `busy` is 1 and `sdata` shows b1 of the frame. `din` must be stable from the strobe rise through P2.
- R3: When no strobe edge occurs, no frame is produced: `busy`, `sdata` and `sclk` stay 0.
- R4: A frame is 26 bits, b1..b26, one bit per clock cycle. b1..b22 carry `din[0]`..`din[21]` in that order (LSB first).
- R5: b23, b24, b25 and b26 are the boundary code 1, 0, 1, 0.
- R6: While a frame bit is shown, `sclk` is 1 for odd-numbered bits and 0 for even-numbered bits, so it toggles every cycle. `sclk` is 0 whenever `busy` is 0.
- R7: `busy` is 1 exactly during the cycles that show frame bits, and each run of `busy` lasts a whole multiple of 26 cycles unless it is cut by `en`.
- R8: A strobe detected during a frame, including in the b26 cycle, is sent as the next frame. That frame's b1 follows the previous b26 in the next cycle, so `busy` stays high for 52 cycles in a row.
- R9: A strobe detected while a frame is in flight and the holding slot is already full is dropped.
- R10: A strobe rising edge detected while `en` is low is ignored and produces no frame after `en` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; low silences the outputs and clears the holding slot |
| strobe | input | 1 | Asynchronous word strobe; its rising edge requests one frame |
| din | input | 22 | Parallel word captured at strobe detection |
| sdata | output | 1 | Serial data, LSB first, then the boundary code |
| sclk | output | 1 | Forwarded DDR clock, toggling only during frames |
| busy | output | 1 | High while frame bits are on the line |

## Verification
Three events can fall in the same cycle: the end of a frame (its b26 cycle), the detection of a new strobe, and the release of a held word. Directed cases provoke each combination. A strobe is spaced exactly 26 cycles after the previous one, so it is detected in the b26 cycle, and three strobes are packed inside one frame so that a held word meets a third strobe. Each case is judged at the ports: the bench decodes every frame against an independent list of expected words, and it measures how many cycles in a row `busy` stays high. An extra frame, a missing frame or a one-cycle gap therefore all show up.

// File: rtl/strobe_ddr_serializer.sv
module strobe_ddr_serializer #(
  parameter int DATA_W = 22,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] CODE = 4'b0101,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              strobe,
  input  logic [DATA_W-1:0] din,
  output logic              sdata,
  output logic              sclk,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + CODE_W;
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [SYNC_N-1:0]  sync_q;
  logic               sync_last;
  logic [FRAME_W-2:0] shr;
  logic [CNT_W-1:0]   cnt;
  logic               hold_v;
  logic [DATA_W-1:0]  hold_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      sync_last <= 1'b0;
    end else begin
      sync_q    <= {sync_q[SYNC_N-2:0], strobe};
      sync_last <= sync_q[SYNC_N-1];
    end
  end

  wire rise      = en && sync_q[SYNC_N-1] && !sync_last;
  wire last      = busy && (cnt == CNT_W'(FRAME_W));
  wire from_hold = last && hold_v;
  wire from_in   = rise && (!busy || (last && !hold_v));
  wire start     = from_hold || from_in;

  wire [DATA_W-1:0]  word  = from_hold ? hold_d : din;
  wire [FRAME_W-1:0] frame = {CODE, word};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sdata  <= 1'b0;
      sclk   <= 1'b0;
      busy   <= 1'b0;
      cnt    <= '0;
      shr    <= '0;
      hold_v <= 1'b0;
      hold_d <= '0;
    end else begin
      if (start) begin
        sdata <= frame[0];
        shr   <= frame[FRAME_W-1:1];
        cnt   <= CNT_W'(1);
        sclk  <= 1'b1;
        busy  <= 1'b1;
      end else if (last) begin
        sdata <= 1'b0;
        sclk  <= 1'b0;
        busy  <= 1'b0;
        cnt   <= '0;
      end else if (busy) begin
        sdata <= shr[0];
        shr   <= shr >> 1;
        cnt   <= cnt + CNT_W'(1);
        sclk  <= ~sclk;
      end

      if (from_hold) begin
        hold_v <= rise;
        hold_d <= din;
      end else if (rise && busy && !last && !hold_v) begin
        hold_v <= 1'b1;
        hold_d <= din;
      end
    end
  end
endmodule

// File: rtl/strobe_ddr_serializer_chk.sv
module strobe_ddr_serializer_chk #(
  parameter int DATA_W = 22,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] CODE = 4'b0101
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic sdata,
  input logic sclk,
  input logic busy
);
  localparam int FRAME_W = DATA_W + CODE_W;
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] cidx;

  always_ff @(posedge clk) begin
    if (rst || !en) pos <= '0;
    else if (busy) pos <= (pos == CNT_W'(FRAME_W - 1)) ? '0 : pos + CNT_W'(1);
    else pos <= '0;
  end

  assign cidx = pos - CNT_W'(DATA_W);

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy && !sclk && !sdata);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk && !sdata);

  // R6
  clk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> sclk != $past(sclk));

  // R6
  first_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> sclk);

  // R5
  boundary_code_chk: assert property (@(posedge clk) disable iff (rst)
    busy && pos >= CNT_W'(DATA_W) |-> sdata == CODE[cidx[IDX_W-1:0]]);

  // R7
  whole_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && $past(en) |-> pos == '0);
endmodule

bind strobe_ddr_serializer strobe_ddr_serializer_chk #(
  .DATA_W(DATA_W), .CODE_W(CODE_W), .CODE(CODE)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .sdata(sdata), .sclk(sclk), .busy(busy)
);

// File: tb/strobe_ddr_serializer_tb.sv
module strobe_ddr_serializer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic strobe = 1'b0;
  logic [21:0] din = '0;
  logic sdata, sclk, busy;

  int total = 0;
  int bad = 0;
  int bpos = 0;
  int run_len = 0;
  int last_run = 0;
  logic [25:0] fbits;
  logic [21:0] expq[$];

  always #2 clk = ~clk;

  strobe_ddr_serializer u_dut (
    .clk(clk), .rst(rst), .en(en), .strobe(strobe), .din(din),
    .sdata(sdata), .sclk(sclk), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] frame_word(input logic [25:0] f);
    return f[21:0];
  endfunction

  function automatic logic [3:0] frame_code(input logic [25:0] f);
    return f[25:22];
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (busy) begin
        bpos++;
        run_len++;
        fbits[bpos-1] = sdata;
        check(sclk == bpos[0], "R6 sclk phase", {31'd0, sclk}, {31'd0, bpos[0]});
        if (bpos == 26) begin
          check(frame_code(fbits) == 4'b0101, "R5 boundary code", {28'd0, frame_code(fbits)}, 32'h5);
          if (expq.size() == 0) begin
            check(1'b0, "R3 unexpected frame", {10'd0, frame_word(fbits)}, 32'd0);
          end else begin
            logic [21:0] w;
            w = expq.pop_front();
            check(frame_word(fbits) == w, "R4 payload", {10'd0, frame_word(fbits)}, {10'd0, w});
          end
          bpos = 0;
        end
      end else begin
        check(!sdata && !sclk, "R3 idle lines", {30'd0, sdata, sclk}, 32'd0);
        if (run_len > 0) last_run = run_len;
        run_len = 0;
        bpos = 0;
      end
    end
  end

  task automatic pulse(input logic [21:0] w, input int hi);
    @(negedge clk);
    din = w;
    strobe = 1'b1;
    repeat (hi) @(negedge clk);
    strobe = 1'b0;
    din = 22'($urandom);
  endtask

  task automatic wait_idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    logic [21:0] wa, wb, wc;
    int hcount;
    void'($urandom(32'h5eed));

    repeat (3) @(negedge clk);
    check(!sdata && !sclk && !busy, "R1 reset state", {29'd0, sdata, sclk, busy}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    en = 1'b1;
    wait_idle(30);
    check(!busy, "R3 no strobe no frame", {31'd0, busy}, 32'd0);

    // R2 latency
    wa = 22'h2A5A5B;
    @(negedge clk);
    din = wa;
    strobe = 1'b1;
    expq.push_back(wa);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(!busy, "R2 not before P2", {31'd0, busy}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check(busy && sdata == wa[0], "R2 b1 after P2", {30'd0, busy, sdata}, {30'd0, 1'b1, wa[0]});
    strobe = 1'b0;
    wait_idle(40);
    check(last_run == 26, "R7 single frame length", last_run, 26);

    // R4 extreme words
    pulse(22'h000000, 3); expq.push_back(22'h000000); wait_idle(40);
    pulse(22'h3FFFFF, 4); expq.push_back(22'h3FFFFF); wait_idle(40);
    pulse(22'h000001, 3); expq.push_back(22'h000001); wait_idle(40);
    check(expq.size() == 0, "R4 all frames delivered", expq.size(), 0);

    // R8 strobe detected exactly in b26 cycle
    wa = 22'h155555; wb = 22'h0F0F0F;
    pulse(wa, 3); expq.push_back(wa);
    wait_idle(22);
    pulse(wb, 3); expq.push_back(wb);
    wait_idle(70);
    check(last_run == 52, "R8 back to back on b26", last_run, 52);

    // R8 held word then R9 overflow dropped
    wa = 22'h123456; wb = 22'h3ABCDE; wc = 22'h2FFFF0;
    pulse(wa, 3); expq.push_back(wa);
    wait_idle(5);
    pulse(wb, 3); expq.push_back(wb);
    wait_idle(5);
    pulse(wc, 3);
    wait_idle(90);
    check(last_run == 52, "R8 held word no gap", last_run, 52);
    check(expq.size() == 0, "R9 third strobe dropped", expq.size(), 0);

    // R1 enable drop discards frame and held word
    pulse(22'h0ABCDE, 3);
    wait_idle(5);
    pulse(22'h1CAFE0, 3);
    wait_idle(4);
    en = 1'b0;
    @(negedge clk);
    check(!busy && !sclk && !sdata, "R1 enable low silences", {29'd0, busy, sclk, sdata}, 32'd0);
    @(negedge clk);
    en = 1'b1;
    hcount = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (busy) hcount++;
    end
    check(hcount == 0, "R1 held word discarded", hcount, 0);

    // R10 strobe while disabled
    en = 1'b0;
    wait_idle(3);
    pulse(22'h3C3C3C, 4);
    wait_idle(6);
    en = 1'b1;
    hcount = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy) hcount++;
    end
    check(hcount == 0, "R10 disabled strobe ignored", hcount, 0);

    // random traffic, R4
    for (int k = 0; k < 60; k++) begin
      int hi, gap;
      logic [21:0] w;
      w = 22'($urandom);
      hi = $urandom_range(3, 10);
      gap = $urandom_range(26, 60);
      pulse(w, hi);
      expq.push_back(w);
      repeat (gap - hi - 1) @(negedge clk);
    end
    wait_idle(80);
    check(expq.size() == 0, "R4 random frames delivered", expq.size(), 0);
    check(!busy, "R7 idle after traffic", {31'd0, busy}, 32'd0);

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!sdata && !sclk && !busy, "R1 reset again", {29'd0, sdata, sclk, busy}, 32'd0);
    finish_run();
  end
endmodule